// File: doc/BRIEF.md
# Log-Structured Record Store over Block-Erase Memory

This controller presents four small record slots, selected by a type number, to a client that only issues "read type t" or "write type t with value d". The backing store is a memory that can clear bits but never set them, except by erasing the whole block. The controller never rewrites a record in place. Each update retires the old pointer entry for that type by clearing its valid bit. It then appends the new value into erased space and appends a fresh pointer entry.

The block is split into a pointer area of `PTR_SLOTS` words at the bottom and a data area above it. When either area is exhausted, the controller copies the live records of the other types into a small on-chip buffer. It erases the block, writes those records back from the bottom in type order, and then completes the pending write. After reset it walks the pointer area to rebuild its per-type table and its two free pointers. Every program is checked before and after it is issued. Any storage failure is reported to the client in place of a result.

Top module: `emu_eeprom_ctrl`

## Requirements
- R1: Flash commands on `fl_cmd_o` are encoded 0 none, 1 read word, 2 program word (AND into the stored word), 3 erase block. A command is issued only while `fl_busy_i` is low. The flash raises `fl_busy_i` at the edge that takes the command and lowers it when the result is ready. Read data is valid on `fl_rdata_i` once busy has fallen.
- R2: After reset `busy_o` stays high while the pointer area is scanned. With an erased block, a read of any type then completes with `err_o`=1 and `fault_o`=0.
- R3: Pointer entry format: bit DW-1 is the valid flag, bits DW-2..DW-1-TW hold the type, bits AW-1..0 hold the data address, and all other bits are 1. An entry with valid flag 1 and address all ones is unused. The first write of a type programs the data at the first free data word, starting at address `PTR_SLOTS`. It then programs a valid entry at the first unused pointer slot, starting at slot 0.
- R4: Updating a type that has a record first clears the valid flag of its current entry. It then programs the new data and then a new entry. A read returns the newest value.
- R5: Each program first reads the target word and faults if any bit would have to go from 0 to 1. After programming it reads the word back and faults on a mismatch. A fault ends the request with `fault_o`=1. If invalidation fails, the previous value stays readable.
- R6: A write that finds no free pointer slot or no free data word issues exactly one erase. The surviving records of the other types are rewritten from the block start in ascending type order, followed by the pending record. All values are preserved.
- R7: `busy_o` is high from the cycle after a request is taken until its completion. A request raised while `busy_o` is high is ignored.
- R8: After a reset with a populated block, reads return the newest value of every type. The next write uses the first unused pointer slot and the data word after the highest referenced address.
- R9: `done_o` is a one-cycle pulse. On a successful read, `rdata_o` carries the record in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, taken when `busy_o` is low |
| we_i | input | 1 | 1 write, 0 read |
| type_i | input | TW | Record type |
| wdata_i | input | DW | Write value |
| busy_o | output | 1 | Controller occupied, requests ignored |
| done_o | output | 1 | Completion pulse |
| rdata_o | output | DW | Read result |
| err_o | output | 1 | Read of a type that has no record |
| fault_o | output | 1 | Storage operation failed |
| fl_cmd_o | output | 2 | Flash command |
| fl_addr_o | output | AW | Flash word address |
| fl_wdata_o | output | DW | Flash program data |
| fl_rdata_i | input | DW | Flash read data |
| fl_busy_i | input | 1 | Flash operation in progress |

## Verification
Writes are tried on an erased block, as repeated updates of one type that walk the pointer area, and as the write that overflows it. These separate the first-write placement from invalidate-then-append and from compaction order. The flash contents are inspected directly, so the entry encoding and the invalid flags are checked, not only the read values. A reset over a populated block tells the rebuild scan apart from stale table state. A memory that silently drops programs, and a pre-cleared data word, separately exercise the read-back check and the set-bit check.

// File: rtl/emu_pkg.sv
package emu_pkg;
  typedef enum logic [1:0] {
    FL_NONE  = 2'd0,
    FL_READ  = 2'd1,
    FL_PROG  = 2'd2,
    FL_ERASE = 2'd3
  } fl_cmd_e;

  typedef enum logic [1:0] {
    OP_READ,
    OP_PROG,
    OP_ERASE
  } seq_op_e;

  typedef enum logic [3:0] {
    ST_SCAN,
    ST_IDLE,
    ST_READ,
    ST_INVAL,
    ST_DATA,
    ST_PTR,
    ST_GATHER,
    ST_ERASE,
    ST_FILL_DATA,
    ST_FILL_PTR
  } ctl_st_e;
endpackage

// File: rtl/emu_flash_seq.sv
module emu_flash_seq
  import emu_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  seq_op_e       op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic          fault_o,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    fl_cmd_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_wdata_o,
  input  logic [DW-1:0] fl_rdata_i,
  input  logic          fl_busy_i
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_CMD, SQ_WAIT} sq_e;
  typedef enum logic [2:0] {PH_PRE, PH_PROG, PH_CHECK, PH_READ, PH_ERASE} ph_e;

  sq_e           st_q;
  ph_e           ph_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          done_q, fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      ph_q    <= PH_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        SQ_IDLE: if (start_i) begin
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          fault_q <= 1'b0;
          ph_q    <= (op_i == OP_READ) ? PH_READ : (op_i == OP_PROG) ? PH_PRE : PH_ERASE;
          st_q    <= SQ_CMD;
        end
        SQ_CMD: if (!fl_busy_i) st_q <= SQ_WAIT;
        SQ_WAIT: if (!fl_busy_i) begin
          unique case (ph_q)
            PH_PRE: begin
              // a program can only clear bits
              if ((fl_rdata_i & wdata_q) != wdata_q) begin
                fault_q <= 1'b1;
                done_q  <= 1'b1;
                st_q    <= SQ_IDLE;
              end else begin
                ph_q <= PH_PROG;
                st_q <= SQ_CMD;
              end
            end
            PH_PROG: begin
              ph_q <= PH_CHECK;
              st_q <= SQ_CMD;
            end
            PH_CHECK: begin
              fault_q <= (fl_rdata_i != wdata_q);
              done_q  <= 1'b1;
              st_q    <= SQ_IDLE;
            end
            PH_READ: begin
              rdata_q <= fl_rdata_i;
              done_q  <= 1'b1;
              st_q    <= SQ_IDLE;
            end
            default: begin
              done_q <= 1'b1;
              st_q   <= SQ_IDLE;
            end
          endcase
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_cmd_o = FL_NONE;
    if (st_q == SQ_CMD && !fl_busy_i) begin
      unique case (ph_q)
        PH_PROG:  fl_cmd_o = FL_PROG;
        PH_ERASE: fl_cmd_o = FL_ERASE;
        default:  fl_cmd_o = FL_READ;
      endcase
    end
  end

  assign fl_addr_o  = addr_q;
  assign fl_wdata_o = wdata_q;
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign rdata_o    = rdata_q;

  assert_cmd_taken_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_cmd_o != FL_NONE) |=> fl_busy_i);
endmodule

// File: rtl/emu_ptr_table.sv
module emu_ptr_table #(
  parameter int NTYPES = 4,
  parameter int AW     = 6,
  parameter int SW     = 4,
  localparam int TW    = $clog2(NTYPES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [TW-1:0]     set_type_i,
  input  logic [AW-1:0]     set_addr_i,
  input  logic [SW-1:0]     set_slot_i,
  input  logic              clr_i,
  input  logic [TW-1:0]     clr_type_i,
  input  logic              clr_all_i,
  output logic [NTYPES-1:0] valid_o,
  output logic [AW-1:0]     addr_o [NTYPES],
  output logic [SW-1:0]     slot_o [NTYPES]
);
  for (genvar t = 0; t < NTYPES; t++) begin : g_type
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[t] <= 1'b0;
        addr_o[t]  <= '0;
        slot_o[t]  <= '0;
      end else if (clr_all_i) begin
        valid_o[t] <= 1'b0;
      end else if (set_i && set_type_i == TW'(t)) begin
        valid_o[t] <= 1'b1;
        addr_o[t]  <= set_addr_i;
        slot_o[t]  <= set_slot_i;
      end else if (clr_i && clr_type_i == TW'(t)) begin
        valid_o[t] <= 1'b0;
      end
    end
  end

  assert_clear_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> (valid_o == '0));
endmodule

// File: rtl/emu_rec_buf.sv
module emu_rec_buf #(
  parameter int NTYPES = 4,
  parameter int DW     = 16,
  localparam int TW    = $clog2(NTYPES)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [TW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [TW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [NTYPES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/emu_eeprom_ctrl.sv
module emu_eeprom_ctrl
  import emu_pkg::*;
#(
  parameter int NTYPES    = 4,
  parameter int DW        = 16,
  parameter int AW        = 6,
  parameter int PTR_SLOTS = 8,
  localparam int TW       = $clog2(NTYPES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [TW-1:0] type_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          fault_o,
  output logic [1:0]    fl_cmd_o,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_wdata_o,
  input  logic [DW-1:0] fl_rdata_i,
  input  logic          fl_busy_i
);
  localparam int SW = $clog2(PTR_SLOTS + 1);
  localparam logic [AW-1:0] DATA_BASE = AW'(PTR_SLOTS);
  localparam logic [AW-1:0] DATA_LAST = AW'((1 << AW) - 2);
  localparam logic [SW-1:0] SLOT_CNT  = SW'(PTR_SLOTS);
  localparam logic [TW-1:0] LAST_T    = TW'(NTYPES - 1);

  function automatic logic [DW-1:0] mk_entry(logic v, logic [TW-1:0] t, logic [AW-1:0] a);
    logic [DW-1:0] e;
    e              = '1;
    e[DW-1]        = v;
    e[DW-2 -: TW]  = t;
    e[AW-1:0]      = a;
    return e;
  endfunction

  ctl_st_e       st_q;
  logic          issued_q;
  logic [SW-1:0] scan_idx_q, ptr_free_q;
  logic [AW-1:0] max_end_q, data_free_q;
  logic [TW-1:0] pend_t_q, cur_t_q;
  logic [DW-1:0] pend_data_q;
  logic [NTYPES-1:0] keep_q;
  logic          done_q, err_q, fault_q;
  logic [DW-1:0] rdata_q;

  // sequencer
  logic          seq_start, seq_done, seq_fault, need_op;
  seq_op_e       seq_op;
  logic [AW-1:0] seq_addr;
  logic [DW-1:0] seq_wdata, seq_rdata;

  // pointer table
  logic              tbl_set, tbl_clr, tbl_clr_all;
  logic [TW-1:0]     tbl_set_type;
  logic [AW-1:0]     tbl_set_addr;
  logic [SW-1:0]     tbl_set_slot;
  logic [NTYPES-1:0] tbl_valid;
  logic [AW-1:0]     tbl_addr [NTYPES];
  logic [SW-1:0]     tbl_slot [NTYPES];

  logic [DW-1:0] buf_rdata;

  // scanned entry decode
  logic          e_valid, e_unused;
  logic [TW-1:0] e_type;
  logic [AW-1:0] e_addr, e_end, nxt_end;
  assign e_valid  = seq_rdata[DW-1];
  assign e_type   = seq_rdata[DW-2 -: TW];
  assign e_addr   = seq_rdata[AW-1:0];
  assign e_unused = e_valid && (&e_addr);
  assign e_end    = e_addr + 1'b1;
  assign nxt_end  = (e_end > max_end_q) ? e_end : max_end_q;

  logic has_room;
  assign has_room = (data_free_q <= DATA_LAST) && (ptr_free_q < SLOT_CNT);

  always_comb begin
    seq_op    = OP_PROG;
    seq_addr  = data_free_q;
    seq_wdata = pend_data_q;
    need_op   = 1'b1;
    unique case (st_q)
      ST_SCAN: begin
        seq_op   = OP_READ;
        seq_addr = AW'(scan_idx_q);
      end
      ST_READ: begin
        seq_op   = OP_READ;
        seq_addr = tbl_addr[pend_t_q];
        need_op  = tbl_valid[pend_t_q];
      end
      ST_INVAL: begin
        seq_addr  = AW'(tbl_slot[pend_t_q]);
        seq_wdata = mk_entry(1'b0, pend_t_q, tbl_addr[pend_t_q]);
      end
      ST_PTR: begin
        seq_addr  = AW'(ptr_free_q);
        seq_wdata = mk_entry(1'b1, pend_t_q, data_free_q);
      end
      ST_GATHER: begin
        seq_op   = OP_READ;
        seq_addr = tbl_addr[cur_t_q];
        need_op  = keep_q[cur_t_q];
      end
      ST_ERASE: seq_op = OP_ERASE;
      ST_FILL_DATA: begin
        seq_wdata = buf_rdata;
        need_op   = keep_q[cur_t_q];
      end
      ST_FILL_PTR: begin
        seq_addr  = AW'(ptr_free_q);
        seq_wdata = mk_entry(1'b1, cur_t_q, data_free_q);
      end
      default: ;
    endcase
  end

  assign seq_start = (st_q != ST_IDLE) && !issued_q && need_op;

  always_comb begin
    tbl_set      = 1'b0;
    tbl_set_type = pend_t_q;
    tbl_set_addr = data_free_q;
    tbl_set_slot = ptr_free_q;
    if (seq_done && !seq_fault) begin
      unique case (st_q)
        ST_SCAN: begin
          tbl_set      = e_valid && !e_unused;
          tbl_set_type = e_type;
          tbl_set_addr = e_addr;
          tbl_set_slot = scan_idx_q;
        end
        ST_PTR: tbl_set = 1'b1;
        ST_FILL_PTR: begin
          tbl_set      = 1'b1;
          tbl_set_type = cur_t_q;
        end
        default: ;
      endcase
    end
  end

  assign tbl_clr     = seq_done && !seq_fault && (st_q == ST_INVAL);
  assign tbl_clr_all = seq_done && (st_q == ST_ERASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_SCAN;
      issued_q    <= 1'b0;
      scan_idx_q  <= '0;
      ptr_free_q  <= '0;
      max_end_q   <= DATA_BASE;
      data_free_q <= DATA_BASE;
      pend_t_q    <= '0;
      cur_t_q     <= '0;
      pend_data_q <= '0;
      keep_q      <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
      fault_q     <= 1'b0;
      rdata_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (seq_start) issued_q <= 1'b1;
      if (seq_done)  issued_q <= 1'b0;
      unique case (st_q)
        ST_SCAN: if (seq_done) begin
          if (e_unused) begin
            ptr_free_q  <= scan_idx_q;
            data_free_q <= max_end_q;
            st_q        <= ST_IDLE;
          end else begin
            max_end_q <= nxt_end;
            if (scan_idx_q == SLOT_CNT - 1'b1) begin
              ptr_free_q  <= SLOT_CNT;
              data_free_q <= nxt_end;
              st_q        <= ST_IDLE;
            end else begin
              scan_idx_q <= scan_idx_q + 1'b1;
            end
          end
        end
        ST_IDLE: if (req_i) begin
          pend_t_q    <= type_i;
          pend_data_q <= wdata_i;
          if (!we_i) begin
            st_q <= ST_READ;
          end else if (has_room) begin
            st_q <= tbl_valid[type_i] ? ST_INVAL : ST_DATA;
          end else begin
            keep_q  <= tbl_valid & ~(NTYPES'(1) << type_i);
            cur_t_q <= '0;
            st_q    <= ST_GATHER;
          end
        end
        ST_READ: begin
          if (!tbl_valid[pend_t_q]) begin
            {done_q, err_q, fault_q} <= 3'b110;
            st_q <= ST_IDLE;
          end else if (seq_done) begin
            rdata_q <= seq_rdata;
            {done_q, err_q, fault_q} <= 3'b100;
            st_q <= ST_IDLE;
          end
        end
        ST_INVAL, ST_DATA: if (seq_done) begin
          if (seq_fault) begin
            {done_q, err_q, fault_q} <= 3'b101;
            st_q <= ST_IDLE;
          end else begin
            st_q <= ST_DATA == st_q ? ST_PTR : ST_DATA;
          end
        end
        ST_PTR: if (seq_done) begin
          {done_q, err_q, fault_q} <= {1'b1, 1'b0, seq_fault};
          if (!seq_fault) begin
            data_free_q <= data_free_q + 1'b1;
            ptr_free_q  <= ptr_free_q + 1'b1;
          end
          st_q <= ST_IDLE;
        end
        ST_GATHER: if (!keep_q[cur_t_q] || seq_done) begin
          if (cur_t_q == LAST_T) st_q <= ST_ERASE;
          else cur_t_q <= cur_t_q + 1'b1;
        end
        ST_ERASE: if (seq_done) begin
          data_free_q <= DATA_BASE;
          ptr_free_q  <= '0;
          cur_t_q     <= '0;
          st_q        <= ST_FILL_DATA;
        end
        ST_FILL_DATA: begin
          if (!keep_q[cur_t_q]) begin
            if (cur_t_q == LAST_T) st_q <= ST_DATA;
            else cur_t_q <= cur_t_q + 1'b1;
          end else if (seq_done) begin
            if (seq_fault) begin
              {done_q, err_q, fault_q} <= 3'b101;
              st_q <= ST_IDLE;
            end else begin
              st_q <= ST_FILL_PTR;
            end
          end
        end
        ST_FILL_PTR: if (seq_done) begin
          if (seq_fault) begin
            {done_q, err_q, fault_q} <= 3'b101;
            st_q <= ST_IDLE;
          end else begin
            data_free_q <= data_free_q + 1'b1;
            ptr_free_q  <= ptr_free_q + 1'b1;
            if (cur_t_q == LAST_T) begin
              st_q <= ST_DATA;
            end else begin
              cur_t_q <= cur_t_q + 1'b1;
              st_q    <= ST_FILL_DATA;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  emu_flash_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (seq_start),
    .op_i       (seq_op),
    .addr_i     (seq_addr),
    .wdata_i    (seq_wdata),
    .done_o     (seq_done),
    .fault_o    (seq_fault),
    .rdata_o    (seq_rdata),
    .fl_cmd_o   (fl_cmd_o),
    .fl_addr_o  (fl_addr_o),
    .fl_wdata_o (fl_wdata_o),
    .fl_rdata_i (fl_rdata_i),
    .fl_busy_i  (fl_busy_i)
  );

  emu_ptr_table #(.NTYPES(NTYPES), .AW(AW), .SW(SW)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (tbl_set),
    .set_type_i (tbl_set_type),
    .set_addr_i (tbl_set_addr),
    .set_slot_i (tbl_set_slot),
    .clr_i      (tbl_clr),
    .clr_type_i (pend_t_q),
    .clr_all_i  (tbl_clr_all),
    .valid_o    (tbl_valid),
    .addr_o     (tbl_addr),
    .slot_o     (tbl_slot)
  );

  emu_rec_buf #(.NTYPES(NTYPES), .DW(DW)) u_buf (
    .clk_i   (clk_i),
    .we_i    (seq_done && st_q == ST_GATHER),
    .widx_i  (cur_t_q),
    .wdata_i (seq_rdata),
    .ridx_i  (cur_t_q),
    .rdata_o (buf_rdata)
  );

  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign fault_o = fault_q;
  assign rdata_o = rdata_q;

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_cmd_needs_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_cmd_o != FL_NONE) |-> busy_o);
  assert_req_held_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(pend_data_q) && $stable(pend_t_q));
  assert_status_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(err_o && fault_o));
  assert_free_bounds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_free_q <= SLOT_CNT) && (data_free_q <= DATA_LAST + 1'b1));
endmodule

// File: tb/emu_eeprom_ctrl_test.sv
module emu_eeprom_ctrl_test;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int TW = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [TW-1:0] typ = '0;
  logic [DW-1:0] wdata = '0;
  logic busy_o, done_o, err_o, fault_o;
  logic [DW-1:0] rdata_o;
  logic [1:0] fl_cmd;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic [DW-1:0] fl_rdata = '0;
  logic fl_busy = 1'b0;

  always #5 clk = ~clk;

  emu_eeprom_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .type_i(typ),
    .wdata_i(wdata), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .err_o(err_o), .fault_o(fault_o), .fl_cmd_o(fl_cmd), .fl_addr_o(fl_addr),
    .fl_wdata_o(fl_wdata), .fl_rdata_i(fl_rdata), .fl_busy_i(fl_busy)
  );

  // flash model
  logic [DW-1:0] mem [DEPTH];
  logic [1:0]    m_cmd = '0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0;
  int  m_cnt = 0;
  bit  prog_ignore = 0;
  int  erase_cnt = 0;
  int  proto_bad = 0;
  int  pulse_bad = 0;
  int  checks = 0;
  int  fails = 0;

  always @(posedge clk) begin
    if (fl_busy) begin
      if (fl_cmd != 2'd0) proto_bad++;
      if (m_cnt == 0) begin
        fl_busy <= 1'b0;
        case (m_cmd)
          2'd1: fl_rdata <= mem[m_addr];
          2'd2: if (!prog_ignore) mem[m_addr] = mem[m_addr] & m_wd;
          2'd3: for (int i = 0; i < DEPTH; i++) mem[i] = '1;
          default: ;
        endcase
      end else begin
        m_cnt <= m_cnt - 1;
      end
    end else if (fl_cmd != 2'd0) begin
      fl_busy <= 1'b1;
      m_cmd   <= fl_cmd;
      m_addr  <= fl_addr;
      m_wd    <= fl_wdata;
      m_cnt   <= 1;
      if (fl_cmd == 2'd3) erase_cnt++;
    end
  end

  function automatic logic [DW-1:0] mk_entry(logic v, logic [TW-1:0] t, logic [AW-1:0] a);
    logic [DW-1:0] e;
    e = '1;
    e[DW-1] = v;
    e[DW-2 -: TW] = t;
    e[AW-1:0] = a;
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic erase_model();
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    while (busy_o) @(negedge clk);
  endtask

  task automatic op(input bit w, input logic [TW-1:0] t, input logic [DW-1:0] d,
                    output logic [DW-1:0] rd, output bit e, output bit f);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    req = 1'b1; we = w; typ = t; wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (!done_o) @(negedge clk);
    rd = rdata_o; e = err_o; f = fault_o;
    @(negedge clk);
    if (done_o) pulse_bad++;
  endtask

  task automatic wr_ok(input logic [TW-1:0] t, input logic [DW-1:0] d, input string tag);
    logic [DW-1:0] rd; bit e, f;
    op(1'b1, t, d, rd, e, f);
    check(!e && !f, tag, {14'd0, e, f}, '0);
  endtask

  task automatic rd_ok(input logic [TW-1:0] t, input logic [DW-1:0] exp, input string tag);
    logic [DW-1:0] rd; bit e, f;
    op(1'b0, t, '0, rd, e, f);
    check(!e && !f && rd == exp, tag, rd, exp);
  endtask

  task automatic t_reset();
    logic [DW-1:0] rd; bit e, f;
    erase_model();
    @(negedge clk);
    check(done_o == 1'b0 && fault_o == 1'b0 && fl_cmd == 2'd0, "R2 reset outputs",
          {13'd0, done_o, fault_o, fl_cmd != 2'd0}, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(busy_o == 1'b1, "R2 busy during scan", {15'd0, busy_o}, 16'd1);
    while (busy_o) @(negedge clk);
    op(1'b0, 2'd0, '0, rd, e, f);
    check(e && !f, "R2 empty read err", {14'd0, e, f}, 16'd2);
  endtask

  task automatic t_first_writes();
    wr_ok(2'd0, 16'h1111, "R3 write t0");
    wr_ok(2'd1, 16'h0000, "R3 write t1");
    wr_ok(2'd2, 16'hA5A5, "R3 write t2");
    wr_ok(2'd3, 16'hFFFF, "R3 write t3");
    check(mem[8] == 16'h1111, "R3 data placement", mem[8], 16'h1111);
    check(mem[0] == mk_entry(1'b1, 2'd0, 6'd8), "R3 entry slot0", mem[0], mk_entry(1'b1, 2'd0, 6'd8));
    check(mem[3] == mk_entry(1'b1, 2'd3, 6'd11), "R3 entry slot3", mem[3], mk_entry(1'b1, 2'd3, 6'd11));
    rd_ok(2'd0, 16'h1111, "R9 read t0");
    rd_ok(2'd1, 16'h0000, "R9 read t1");
    rd_ok(2'd2, 16'hA5A5, "R9 read t2");
    rd_ok(2'd3, 16'hFFFF, "R9 read t3");
  endtask

  task automatic t_update();
    int e0 = erase_cnt;
    wr_ok(2'd0, 16'h2222, "R4 update 1");
    wr_ok(2'd0, 16'h3333, "R4 update 2");
    wr_ok(2'd0, 16'h4444, "R4 update 3");
    wr_ok(2'd0, 16'h5555, "R4 update 4");
    check(mem[0] == mk_entry(1'b0, 2'd0, 6'd8), "R4 old entry invalid", mem[0], mk_entry(1'b0, 2'd0, 6'd8));
    check(mem[6] == mk_entry(1'b0, 2'd0, 6'd14), "R4 middle entry invalid", mem[6], mk_entry(1'b0, 2'd0, 6'd14));
    check(mem[7] == mk_entry(1'b1, 2'd0, 6'd15), "R4 newest entry", mem[7], mk_entry(1'b1, 2'd0, 6'd15));
    check(erase_cnt == e0, "R6 no erase while room", 16'(erase_cnt), 16'(e0));
    rd_ok(2'd0, 16'h5555, "R4 newest value");
  endtask

  task automatic t_compact();
    int e0 = erase_cnt;
    @(negedge clk);
    while (busy_o) @(negedge clk);
    req = 1'b1; we = 1'b1; typ = 2'd0; wdata = 16'h6666;
    @(negedge clk);
    req = 1'b0;
    repeat (5) @(negedge clk);
    check(busy_o == 1'b1, "R7 busy in compaction", {15'd0, busy_o}, 16'd1);
    req = 1'b1; we = 1'b1; typ = 2'd2; wdata = 16'hDEAD;
    @(negedge clk);
    req = 1'b0;
    while (!done_o) @(negedge clk);
    check(!fault_o && !err_o, "R6 compaction status", {14'd0, err_o, fault_o}, '0);
    @(negedge clk);
    check(erase_cnt == e0 + 1, "R6 one erase", 16'(erase_cnt), 16'(e0 + 1));
    check(mem[8] == 16'h0000 && mem[9] == 16'hA5A5 && mem[10] == 16'hFFFF,
          "R6 type order", mem[9], 16'hA5A5);
    check(mem[11] == 16'h6666, "R6 pending last", mem[11], 16'h6666);
    check(mem[3] == mk_entry(1'b1, 2'd0, 6'd11), "R6 entry rewritten", mem[3], mk_entry(1'b1, 2'd0, 6'd11));
    check(mem[4] == '1, "R6 slot free", mem[4], '1);
    rd_ok(2'd0, 16'h6666, "R6 read t0");
    rd_ok(2'd1, 16'h0000, "R6 read t1");
    rd_ok(2'd2, 16'hA5A5, "R7 ignored request");
    rd_ok(2'd3, 16'hFFFF, "R6 read t3");
  endtask

  task automatic t_rescan();
    int e0;
    do_reset();
    rd_ok(2'd0, 16'h6666, "R8 rescan t0");
    rd_ok(2'd1, 16'h0000, "R8 rescan t1");
    rd_ok(2'd2, 16'hA5A5, "R8 rescan t2");
    rd_ok(2'd3, 16'hFFFF, "R8 rescan t3");
    wr_ok(2'd1, 16'h7777, "R8 write after rescan");
    check(mem[0] == mk_entry(1'b0, 2'd1, 6'd8), "R8 invalidated", mem[0], mk_entry(1'b0, 2'd1, 6'd8));
    check(mem[4] == mk_entry(1'b1, 2'd1, 6'd12), "R8 next slot", mem[4], mk_entry(1'b1, 2'd1, 6'd12));
    rd_ok(2'd1, 16'h7777, "R8 read new");
    e0 = erase_cnt;
    wr_ok(2'd2, 16'h0101, "R6 fill a");
    wr_ok(2'd2, 16'h0202, "R6 fill b");
    wr_ok(2'd2, 16'h0303, "R6 fill c");
    wr_ok(2'd3, 16'hABCD, "R6 second compaction");
    check(erase_cnt == e0 + 1, "R6 second erase", 16'(erase_cnt), 16'(e0 + 1));
    check(mem[10] == 16'h0303, "R6 order second", mem[10], 16'h0303);
    rd_ok(2'd0, 16'h6666, "R6 keep t0");
    rd_ok(2'd1, 16'h7777, "R6 keep t1");
    rd_ok(2'd2, 16'h0303, "R6 keep t2");
    rd_ok(2'd3, 16'hABCD, "R6 new t3");
  endtask

  task automatic t_fault_verify();
    logic [DW-1:0] rd; bit e, f;
    prog_ignore = 1;
    op(1'b1, 2'd2, 16'h1357, rd, e, f);
    prog_ignore = 0;
    check(f && !e, "R5 readback fault", {14'd0, e, f}, 16'd1);
    rd_ok(2'd2, 16'h0303, "R5 old value kept");
  endtask

  task automatic t_fault_zero();
    logic [DW-1:0] rd; bit e, f;
    erase_model();
    mem[8] = 16'h0000;
    do_reset();
    op(1'b1, 2'd3, 16'h00FF, rd, e, f);
    check(f && !e, "R5 set-bit fault", {14'd0, e, f}, 16'd1);
    check(mem[0] == '1, "R5 no entry written", mem[0], '1);
    op(1'b0, 2'd3, '0, rd, e, f);
    check(e && !f, "R5 no record after fault", {14'd0, e, f}, 16'd2);
  endtask

  initial begin
    t_reset();
    t_first_writes();
    t_update();
    t_compact();
    t_rescan();
    t_fault_verify();
    t_fault_zero();
    check(proto_bad == 0, "R1 no command while flash busy", 16'(proto_bad), '0);
    check(pulse_bad == 0, "R9 done single cycle", 16'(pulse_bad), '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule